// File: doc/BRIEF.md
# Split Condition-Flag Rename Tracker

This block sits in the rename stage of an out-of-order core and records, for two condition-flag groups, which in-flight instruction produced each one most recently. The carry flag is one group. Zero, sign, overflow, parity and adjust form the other group. Every instruction that enters says which groups it writes and which it reads. The block returns the tags of the producers the instruction depends on. Because the two groups are tracked apart, an increment that leaves carry untouched does not depend on anything.

A reader whose two groups come from different in-flight producers needs a merged view of the flags. Under the default policy the block emits a merge micro-op ahead of that reader, gives it a fresh tag from an internal counter, and does not stop the front end. Under the legacy policy it holds the front end for a fixed number of cycles instead. Under the whole-register policy both groups always share one producer, and a partial write becomes a read-modify-write of the previous flags. Retirement clears a group back to the architectural state, and a flush clears both groups in one cycle.

Top module: `flag_rename_tracker`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, both groups are architectural, so a reader receives no valid source tag. A flush also cancels any hold that is in progress, and `stall` is low and `in_ready` is high in the next cycle.
- R2: Under the split policies (policy 0 merge, 1 stall, 3 treated as 0), a write of the non-carry group only reports no source. The carry group keeps its earlier producer, and a later carry reader receives that producer's tag.
- R3: Under the split policies, an instruction that writes both groups makes itself the only producer. A later reader of both groups receives its tag on both source outputs and causes no merge.
- R4: A reader of one group, or of both groups when they share a producer or when either group is architectural, receives the current producer tag of each group it reads, with valid set. It causes no merge and no hold.
- R5: Under policy 0, a reader of both groups whose producers are valid and differ is accepted without a hold. In the next cycle `insert_merge` pulses and `merge_in_cf_tag`/`merge_in_oth_tag` give the two old producers. Both reader source outputs give `merge_tag`.
- R6: A merge tag has its most significant bit set and carries, in its low bits, a counter that starts at 0 after reset and advances by one on each merge, wrapping at 2^MRG_W. Destination tags supplied at `in_dest_tag` must have that bit clear.
- R7: After a merge, every group that the reader does not write has the merge tag as its producer.
- R8: Under policy 1, the same split read holds `in_ready` low for STALL_CYCLES+1 cycles, with `stall` high for STALL_CYCLES of them. The reader is then accepted with no valid source and no merge, and any group it does not write becomes architectural.
- R9: Under policy 2, both source outputs always carry the same value. A write of only one group, or any flag read, reports the single previous producer. A write of both groups with no read reports nothing. Any write makes the instruction the producer of both groups.
- R10: When `in_flags_dead` is set, the flag reads and writes of that instruction are ignored. It reports no source, causes no merge, and leaves both producers unchanged.
- R11: When `ret_valid` is high and `ret_tag` equals a group's valid producer, that group becomes architectural. This does not happen if the same group is written in the same cycle.
- R12: Results appear on the registered outputs in the cycle after acceptance. `iss_valid` is high for exactly one cycle per accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | 0 merge micro-op, 1 legacy hold, 2 whole register, 3 as 0; change only together with a flush |
| flush | input | 1 | Clears both groups and any hold |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when both are high |
| in_write_cf | input | 1 | Writes carry |
| in_write_oth | input | 1 | Writes the other arithmetic flags |
| in_read_cf | input | 1 | Reads carry |
| in_read_oth | input | 1 | Reads the other arithmetic flags |
| in_flags_dead | input | 1 | Flag result and flag inputs may be dropped |
| in_dest_tag | input | TAG_W | Tag of the offered instruction, top bit clear |
| ret_valid | input | 1 | A producer retires |
| ret_tag | input | TAG_W | Tag of the retiring producer |
| iss_valid | output | 1 | One-cycle pulse per accepted instruction |
| src_cf_valid | output | 1 | Reader depends on an in-flight carry producer |
| src_cf_tag | output | TAG_W | That producer's tag, zero when not valid |
| src_oth_valid | output | 1 | Reader depends on an in-flight non-carry producer |
| src_oth_tag | output | TAG_W | That producer's tag, zero when not valid |
| insert_merge | output | 1 | A merge micro-op precedes the reader |
| merge_tag | output | TAG_W | Tag of the merge micro-op |
| merge_in_cf_tag | output | TAG_W | Carry producer the merge reads |
| merge_in_oth_tag | output | TAG_W | Non-carry producer the merge reads |
| stall | output | 1 | Legacy hold in progress |

## Verification
The assertions check several rules on every cycle. A hold always blocks acceptance. A merge pulse always comes with an issue whose two sources are the merge tag, and that tag has its top bit set. No merge is ever produced under the hold policy. A flush leaves both groups architectural. Every issue pulse follows exactly one acceptance, and under the whole-register policy the two source outputs agree. Other behaviour can be shown only by the directed scenarios. These cover carry surviving an increment, a full write breaking both chains, the exact merge inputs and the counter sequence, the length of the hold and the state it leaves, a flush that cuts a hold short, the false dependency taken by a partial write under the whole-register policy, retirement, and the dead-flags hint.

// File: rtl/flag_rename_pkg.sv
package flag_rename_pkg;
   typedef enum logic [1:0] {
      POL_MERGE = 2'd0,
      POL_STALL = 2'd1,
      POL_WHOLE = 2'd2,
      POL_RSVD  = 2'd3
   } flag_policy_e;

   localparam int GRP_CF  = 0;
   localparam int GRP_OTH = 1;
   localparam int N_GRP   = 2;
endpackage

// File: rtl/flag_group_slot.sv
// Holds the producer of one flag group.
// Priority: flush, then a write, then a matching retirement.
module flag_group_slot #(
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic             wr_vld,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             ret_valid,
   input  logic [TAG_W-1:0] ret_tag,
   output logic             vld,
   output logic [TAG_W-1:0] tag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= 1'b0;
         tag <= '0;
      end else if (flush) begin
         vld <= 1'b0;
      end else if (wr_en) begin
         vld <= wr_vld;
         tag <= wr_tag;
      end else if (ret_valid && vld && (ret_tag == tag)) begin
         vld <= 1'b0;
      end
   end
endmodule

// File: rtl/merge_tag_pool.sv
// Hands out merge tags: top bit set, low bits from a wrapping counter.
module merge_tag_pool #(
   parameter int TAG_W = 6,
   parameter int MRG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   output logic [TAG_W-1:0] tag_o
);
   localparam logic [TAG_W-1:0] TAG_BASE = TAG_W'(1) << (TAG_W - 1);

   logic [MRG_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (take) cnt_q <= cnt_q + MRG_W'(1);
   end

   assign tag_o = TAG_BASE | TAG_W'(cnt_q);
endmodule

// File: rtl/stall_timer.sv
// Counts the legacy hold and then grants one acceptance.
module stall_timer #(
   parameter int STALL_CYCLES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic start,
   input  logic consume,
   output logic busy,
   output logic granted
);
   localparam int CNT_W = $clog2(STALL_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(STALL_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         cnt_q   <= '0;
         granted <= 1'b0;
      end else begin
         if (start)               cnt_q <= LOAD;
         else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1))  granted <= 1'b1;
         else if (consume)        granted <= 1'b0;
      end
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/flag_rename_tracker.sv
module flag_rename_tracker
   import flag_rename_pkg::*;
#(
   parameter int TAG_W        = 6,
   parameter int MRG_W        = 3,
   parameter int STALL_CYCLES = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       policy,
   input  logic             flush,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_write_cf,
   input  logic             in_write_oth,
   input  logic             in_read_cf,
   input  logic             in_read_oth,
   input  logic             in_flags_dead,
   input  logic [TAG_W-1:0] in_dest_tag,
   input  logic             ret_valid,
   input  logic [TAG_W-1:0] ret_tag,
   output logic             iss_valid,
   output logic             src_cf_valid,
   output logic [TAG_W-1:0] src_cf_tag,
   output logic             src_oth_valid,
   output logic [TAG_W-1:0] src_oth_tag,
   output logic             insert_merge,
   output logic [TAG_W-1:0] merge_tag,
   output logic [TAG_W-1:0] merge_in_cf_tag,
   output logic [TAG_W-1:0] merge_in_oth_tag,
   output logic             stall
);
   if (TAG_W < 2) begin : g_bad_tag
      $error("TAG_W must be at least 2");
   end
   if (MRG_W < 1 || MRG_W > TAG_W - 1) begin : g_bad_mrg
      $error("MRG_W must lie in 1..TAG_W-1");
   end
   if (STALL_CYCLES < 1) begin : g_bad_stall
      $error("STALL_CYCLES must be at least 1");
   end

   flag_policy_e pol;
   assign pol = flag_policy_e'(policy);

   logic             pol_stall, pol_whole, pol_merge;
   assign pol_stall = (pol == POL_STALL);
   assign pol_whole = (pol == POL_WHOLE);
   assign pol_merge = !pol_stall && !pol_whole;

   // A dead flag result drops the reads and the writes of flags
   logic [N_GRP-1:0] rd_g, wr_g;
   assign rd_g[GRP_CF]  = in_read_cf   & ~in_flags_dead;
   assign rd_g[GRP_OTH] = in_read_oth  & ~in_flags_dead;
   assign wr_g[GRP_CF]  = in_write_cf  & ~in_flags_dead;
   assign wr_g[GRP_OTH] = in_write_oth & ~in_flags_dead;

   logic [N_GRP-1:0] grp_vld;
   logic [TAG_W-1:0] grp_tag [N_GRP];

   logic             split_need;
   assign split_need = (&rd_g) && (&grp_vld) && (grp_tag[GRP_CF] != grp_tag[GRP_OTH]);

   // Legacy hold control
   logic busy, granted, need_hold, timer_start, accept;
   assign need_hold   = in_valid && pol_stall && split_need && !granted;
   assign timer_start = need_hold && !busy && !flush;
   assign in_ready    = !flush && !busy && !need_hold;
   assign accept      = in_valid && in_ready;

   stall_timer #(.STALL_CYCLES(STALL_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .start   (timer_start),
      .consume (accept),
      .busy    (busy),
      .granted (granted)
   );

   logic do_merge, do_held;
   assign do_merge = accept && pol_merge && split_need;
   assign do_held  = accept && pol_stall && split_need;

   logic [TAG_W-1:0] mtag;
   merge_tag_pool #(.TAG_W(TAG_W), .MRG_W(MRG_W)) u_pool (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (do_merge),
      .tag_o (mtag)
   );

   // Whole-register view: one producer shared by both groups
   logic any_wr, partial_wr, whole_rd;
   assign any_wr     = |wr_g;
   assign partial_wr = any_wr && !(&wr_g);
   assign whole_rd   = (|rd_g) || partial_wr;

   logic             nxt_vld [N_GRP];
   logic [TAG_W-1:0] nxt_tag [N_GRP];

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic             s_wr_en, s_wr_vld;
      logic [TAG_W-1:0] s_wr_tag;

      always_comb begin
         s_wr_en  = 1'b0;
         s_wr_vld = 1'b1;
         s_wr_tag = in_dest_tag;
         if (pol_whole) begin
            s_wr_en = accept && any_wr;
         end else if (do_merge) begin
            s_wr_en  = 1'b1;
            s_wr_tag = wr_g[g] ? in_dest_tag : mtag;
         end else if (do_held) begin
            s_wr_en  = 1'b1;
            s_wr_vld = wr_g[g];
         end else begin
            s_wr_en = accept && wr_g[g];
         end
      end

      always_comb begin
         if (pol_whole) begin
            nxt_vld[g] = whole_rd && grp_vld[GRP_OTH];
            nxt_tag[g] = grp_tag[GRP_OTH];
         end else if (do_merge) begin
            nxt_vld[g] = 1'b1;
            nxt_tag[g] = mtag;
         end else if (do_held) begin
            nxt_vld[g] = 1'b0;
            nxt_tag[g] = '0;
         end else begin
            nxt_vld[g] = rd_g[g] && grp_vld[g];
            nxt_tag[g] = grp_tag[g];
         end
      end

      flag_group_slot #(.TAG_W(TAG_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush),
         .wr_en     (s_wr_en),
         .wr_vld    (s_wr_vld),
         .wr_tag    (s_wr_tag),
         .ret_valid (ret_valid),
         .ret_tag   (ret_tag),
         .vld       (grp_vld[g]),
         .tag       (grp_tag[g])
      );
   end

   // Registered result stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iss_valid        <= 1'b0;
         src_cf_valid     <= 1'b0;
         src_cf_tag       <= '0;
         src_oth_valid    <= 1'b0;
         src_oth_tag      <= '0;
         insert_merge     <= 1'b0;
         merge_tag        <= '0;
         merge_in_cf_tag  <= '0;
         merge_in_oth_tag <= '0;
      end else begin
         iss_valid     <= accept;
         insert_merge  <= do_merge;
         src_cf_valid  <= accept && nxt_vld[GRP_CF];
         src_oth_valid <= accept && nxt_vld[GRP_OTH];
         src_cf_tag    <= (accept && nxt_vld[GRP_CF])  ? nxt_tag[GRP_CF]  : '0;
         src_oth_tag   <= (accept && nxt_vld[GRP_OTH]) ? nxt_tag[GRP_OTH] : '0;
         if (do_merge) begin
            merge_tag        <= mtag;
            merge_in_cf_tag  <= grp_tag[GRP_CF];
            merge_in_oth_tag <= grp_tag[GRP_OTH];
         end
      end
   end

   assign stall = busy;
endmodule

// File: rtl/flag_rename_tracker_checker.sv
module flag_rename_tracker_checker #(
   parameter int TAG_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       policy,
   input logic             flush,
   input logic             in_valid,
   input logic             in_ready,
   input logic             iss_valid,
   input logic             src_cf_valid,
   input logic [TAG_W-1:0] src_cf_tag,
   input logic             src_oth_valid,
   input logic [TAG_W-1:0] src_oth_tag,
   input logic             insert_merge,
   input logic [TAG_W-1:0] merge_tag,
   input logic             stall,
   input logic [1:0]       grp_vld
);
   assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !in_ready);

   assert_no_merge_when_holding_R8: assert property (@(posedge clk) disable iff (!rst_n)
      insert_merge |-> $past(policy) != 2'd1);

   assert_merge_feeds_reader_R5: assert property (@(posedge clk) disable iff (!rst_n)
      insert_merge |-> iss_valid && src_cf_valid && src_oth_valid
                       && src_cf_tag == merge_tag && src_oth_tag == merge_tag);

   assert_merge_tag_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
      insert_merge |-> merge_tag[TAG_W-1]);

   assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush) |-> (grp_vld == 2'b00) && !stall);

   assert_issue_follows_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> $past(in_valid && in_ready));

   assert_whole_single_producer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && $past(policy) == 2'd2) |->
         (src_cf_valid == src_oth_valid) && (src_cf_tag == src_oth_tag));
endmodule

bind flag_rename_tracker flag_rename_tracker_checker #(.TAG_W(TAG_W)) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .policy        (policy),
   .flush         (flush),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .iss_valid     (iss_valid),
   .src_cf_valid  (src_cf_valid),
   .src_cf_tag    (src_cf_tag),
   .src_oth_valid (src_oth_valid),
   .src_oth_tag   (src_oth_tag),
   .insert_merge  (insert_merge),
   .merge_tag     (merge_tag),
   .stall         (stall),
   .grp_vld       (grp_vld)
);

// File: tb/flag_rename_tracker_bench.sv
module flag_rename_tracker_bench;
   localparam int TAG_W = 6;
   localparam int STALL = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       policy = 2'd0;
   logic             flush = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic             in_write_cf = 1'b0, in_write_oth = 1'b0;
   logic             in_read_cf = 1'b0, in_read_oth = 1'b0;
   logic             in_flags_dead = 1'b0;
   logic [TAG_W-1:0] in_dest_tag = '0;
   logic             ret_valid = 1'b0;
   logic [TAG_W-1:0] ret_tag = '0;
   logic             iss_valid, src_cf_valid, src_oth_valid, insert_merge, stall;
   logic [TAG_W-1:0] src_cf_tag, src_oth_tag, merge_tag, merge_in_cf_tag, merge_in_oth_tag;

   int checks = 0;
   int errors = 0;
   int hold_n, stall_n;

   always #10 clk = ~clk;

   flag_rename_tracker #(.TAG_W(TAG_W), .MRG_W(3), .STALL_CYCLES(STALL)) u_flag_rename_tracker (
      .clk(clk), .rst_n(rst_n), .policy(policy), .flush(flush),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_write_cf(in_write_cf), .in_write_oth(in_write_oth),
      .in_read_cf(in_read_cf), .in_read_oth(in_read_oth),
      .in_flags_dead(in_flags_dead), .in_dest_tag(in_dest_tag),
      .ret_valid(ret_valid), .ret_tag(ret_tag),
      .iss_valid(iss_valid),
      .src_cf_valid(src_cf_valid), .src_cf_tag(src_cf_tag),
      .src_oth_valid(src_oth_valid), .src_oth_tag(src_oth_tag),
      .insert_merge(insert_merge), .merge_tag(merge_tag),
      .merge_in_cf_tag(merge_in_cf_tag), .merge_in_oth_tag(merge_in_oth_tag),
      .stall(stall)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Offers one instruction and returns at the negedge where its results show
   task automatic issue(input bit wcf, input bit woth, input bit rcf, input bit roth,
                        input bit dead, input int dest);
      @(negedge clk);
      in_write_cf = wcf; in_write_oth = woth; in_read_cf = rcf; in_read_oth = roth;
      in_flags_dead = dead; in_dest_tag = TAG_W'(dest); in_valid = 1'b1;
      hold_n = 0; stall_n = 0;
      forever begin
         #1;
         if (in_ready) begin
            @(negedge clk);
            in_valid = 1'b0;
            break;
         end
         hold_n++;
         if (stall) stall_n++;
         @(negedge clk);
      end
   endtask

   task automatic expect_src(input string req, input int cv, input int ct, input int ov, input int ot);
      check(req, "src_cf_valid", src_cf_valid, cv);
      if (cv != 0) check(req, "src_cf_tag", src_cf_tag, ct);
      check(req, "src_oth_valid", src_oth_valid, ov);
      if (ov != 0) check(req, "src_oth_tag", src_oth_tag, ot);
   endtask

   task automatic do_flush(input logic [1:0] pol);
      @(negedge clk);
      policy = pol; flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic t_reset;
      check("R1", "in_ready after reset", in_ready, 1);
      check("R1", "stall after reset", stall, 0);
      check("R12", "iss_valid after reset", iss_valid, 0);
      issue(0, 0, 1, 1, 0, 1);
      check("R12", "iss_valid pulse", iss_valid, 1);
      expect_src("R1", 0, 0, 0, 0);
      check("R4", "no merge on architectural read", insert_merge, 0);
      @(negedge clk);
      check("R12", "iss_valid single cycle", iss_valid, 0);
   endtask

   task automatic t_carry_kept;
      do_flush(2'd0);
      issue(1, 1, 0, 0, 0, 5);
      expect_src("R3", 0, 0, 0, 0);
      issue(0, 1, 0, 0, 0, 6);
      expect_src("R2", 0, 0, 0, 0);
      issue(0, 0, 1, 0, 0, 7);
      expect_src("R2", 1, 5, 0, 0);
      check("R4", "no merge single group", insert_merge, 0);
      issue(0, 0, 0, 1, 0, 7);
      expect_src("R4", 0, 0, 1, 6);
   endtask

   task automatic t_merge;
      issue(0, 0, 1, 1, 0, 8);
      check("R5", "no hold", hold_n, 0);
      check("R5", "insert_merge", insert_merge, 1);
      check("R6", "first merge tag", merge_tag, 32);
      check("R5", "merge carry input", merge_in_cf_tag, 5);
      check("R5", "merge other input", merge_in_oth_tag, 6);
      expect_src("R5", 1, 32, 1, 32);
      issue(0, 0, 1, 1, 0, 9);
      check("R7", "no second merge", insert_merge, 0);
      expect_src("R7", 1, 32, 1, 32);
      issue(0, 1, 0, 0, 0, 10);
      issue(0, 0, 1, 1, 0, 11);
      check("R6", "second merge tag", merge_tag, 33);
      check("R5", "second merge carry input", merge_in_cf_tag, 32);
      check("R5", "second merge other input", merge_in_oth_tag, 10);
   endtask

   task automatic t_full_write;
      do_flush(2'd0);
      issue(0, 1, 0, 0, 0, 3);
      issue(1, 1, 0, 0, 0, 4);
      issue(0, 0, 1, 1, 0, 12);
      check("R3", "no merge after full write", insert_merge, 0);
      expect_src("R3", 1, 4, 1, 4);
   endtask

   task automatic t_retire;
      do_flush(2'd0);
      issue(1, 1, 0, 0, 0, 10);
      issue(0, 1, 0, 0, 0, 11);
      @(negedge clk);
      ret_valid = 1'b1; ret_tag = 6'd10;
      @(negedge clk);
      ret_valid = 1'b0;
      issue(0, 0, 1, 1, 0, 13);
      check("R11", "no merge after retire", insert_merge, 0);
      expect_src("R11", 0, 0, 1, 11);
   endtask

   task automatic t_stall;
      do_flush(2'd1);
      issue(1, 1, 0, 0, 0, 12);
      issue(0, 1, 0, 0, 0, 13);
      issue(0, 0, 1, 1, 0, 14);
      check("R8", "ready-low cycles", hold_n, STALL + 1);
      check("R8", "stall-high cycles", stall_n, STALL);
      check("R8", "no merge in hold mode", insert_merge, 0);
      expect_src("R8", 0, 0, 0, 0);
      issue(0, 0, 1, 1, 0, 15);
      check("R8", "groups architectural after hold", hold_n, 0);
      expect_src("R8", 0, 0, 0, 0);
   endtask

   task automatic t_flush_cancel;
      do_flush(2'd1);
      issue(1, 1, 0, 0, 0, 15);
      issue(0, 1, 0, 0, 0, 16);
      @(negedge clk);
      in_read_cf = 1; in_read_oth = 1; in_write_cf = 0; in_write_oth = 0;
      in_flags_dead = 0; in_dest_tag = 6'd17; in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R8", "stall mid hold", stall, 1);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      #1;
      check("R1", "stall cancelled by flush", stall, 0);
      check("R1", "ready after flush", in_ready, 1);
      @(negedge clk);
      in_valid = 1'b0;
      check("R1", "accepted after flush", iss_valid, 1);
      expect_src("R1", 0, 0, 0, 0);
   endtask

   task automatic t_whole;
      do_flush(2'd2);
      issue(1, 1, 0, 0, 0, 20);
      expect_src("R9", 0, 0, 0, 0);
      issue(0, 1, 0, 0, 0, 21);
      expect_src("R9", 1, 20, 1, 20);
      issue(0, 0, 1, 0, 0, 22);
      expect_src("R9", 1, 21, 1, 21);
      check("R9", "no merge in whole mode", insert_merge, 0);
      issue(1, 1, 0, 0, 0, 23);
      expect_src("R9", 0, 0, 0, 0);
   endtask

   task automatic t_dead;
      do_flush(2'd0);
      issue(1, 1, 0, 0, 0, 24);
      issue(0, 1, 0, 0, 0, 25);
      issue(1, 1, 1, 1, 1, 26);
      check("R10", "no merge for dead flags", insert_merge, 0);
      expect_src("R10", 0, 0, 0, 0);
      issue(0, 0, 1, 0, 0, 27);
      expect_src("R10", 1, 24, 0, 0);
      issue(0, 0, 0, 1, 0, 27);
      expect_src("R10", 0, 0, 1, 25);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_carry_kept();
      t_merge();
      t_full_write();
      t_retire();
      t_stall();
      t_flush_cancel();
      t_whole();
      t_dead();
      finish_run();
   end

   initial begin
      #(20 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule